// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core with five pipeline stages: fetch, decode with register read, execute, memory access and writeback. It runs a reduced instruction set of register add and subtract, word load, word store, branch-if-equal and a halt word. Instructions and data live in two internal byte-addressed memories. The surrounding environment fills them through a byte-wide load port, normally while reset is held.

Branches are resolved in decode with a static not-taken guess. A taken branch kills the one instruction that was fetched behind it by setting that instruction's nop bit, and no other bubble is added. Data dependences are covered by forwarding into the execute stage and by a register file that passes a same-cycle write through to its readers. The only stall is one cycle when an instruction uses a value loaded by the instruction directly ahead of it. The halt word stops fetching and lets older work drain, and the core then raises a sticky halted flag.

Debug taps expose the PC, the nop bit of each pipeline register, the writeback port, one register-file read port and one data-memory word read port.

Top module: `pipe5_core`

## Requirements
- R1: A word at byte address A is formed big-endian from bytes A..A+3, with the byte at A in bits 31:24. Word loads, word stores, instruction fetch and the debug memory port all use this order.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0] and immediate [15:0]. Opcode 0x00 with function 0x20 writes rs+rt to rd, and with function 0x22 writes rs-rt to rd. Opcode 0x23 loads the word at rs+sext(imm) into rt. Opcode 0x2B stores rt to rs+sext(imm).
- R3: An ALU result is forwarded to a dependent instruction one or two slots behind it, with no stall cycle.
- R4: An instruction that reads, as an ALU or store operand, the register loaded by the instruction directly ahead of it is held for exactly one cycle. During that cycle the PC holds and a bubble enters the execute stage.
- R5: Opcode 0x04 compares rs and rt in decode. When they are equal, fetch continues at PC+4+(sext(imm)<<2) and the single wrongly fetched instruction is killed, which costs one cycle. When they differ, no cycle is lost.
- R6: The word 0xFFFFFFFF halts the core. Once it is fetched, nothing behind it executes. The halted output rises on the clock edge after the halt word leaves writeback and stays high until reset.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: A register read in decode in the same cycle that writeback writes it returns the new value.
- R9: After reset all four stage nop bits are 1, halted is 0, every register reads 0 and the PC is 0.
- R10: dbg_stage_nop bit 0 is the fetch/decode register, bit 1 decode/execute, bit 2 execute/memory and bit 3 memory/writeback. All four bits are 1 while halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one byte into a memory |
| ld_sel | input | 1 | Memory selected by ld_en: 0 instruction, 1 data |
| ld_addr | input | MAW | Byte address for ld_en |
| ld_byte | input | 8 | Byte value for ld_en |
| halted | output | 1 | Sticky flag set after the halt word drains |
| dbg_pc | output | 32 | Current fetch PC |
| dbg_stage_nop | output | 4 | Nop bit of each pipeline register (see R10) |
| dbg_wb_en | output | 1 | Writeback stage writes a register this cycle |
| dbg_wb_reg | output | 5 | Register written by writeback |
| dbg_wb_data | output | 32 | Value written by writeback |
| dbg_reg_sel | input | 5 | Register number for the debug read |
| dbg_reg_val | output | 32 | Content of the selected register |
| dbg_mem_addr | input | MAW | Byte address for the debug data-memory read |
| dbg_mem_word | output | 32 | Big-endian word at dbg_mem_addr |

## Verification
The collision that matters is a branch comparing its operands in decode in the same cycle that writeback stores one of them. Because branches get no forwarding, the result depends entirely on the register file's same-cycle pass-through. The test programs place a producer exactly three slots ahead of a branch, both in straight-line code and inside a counted loop. Correctness is judged from the branch direction taken, which shows in the stream of writebacks, in the final memory contents and in the total cycle count, since each taken branch adds exactly one cycle.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

   localparam int XW     = 32;
   localparam int REG_AW = 5;

   localparam logic [5:0] OP_ALU = 6'h00;
   localparam logic [5:0] OP_LW  = 6'h23;
   localparam logic [5:0] OP_SW  = 6'h2B;
   localparam logic [5:0] OP_BEQ = 6'h04;
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [XW-1:0] HALT_WORD = '1;

   typedef enum logic [1:0] {FWD_RF, FWD_EXM, FWD_MWB} fwd_e;

   typedef struct packed {
      logic          nop;
      logic [XW-1:0] instr;
      logic [XW-1:0] pc4;
   } ifid_t;

   typedef struct packed {
      logic              nop;
      logic [REG_AW-1:0] rs;
      logic [REG_AW-1:0] rt;
      logic [REG_AW-1:0] dst;
      logic [XW-1:0]     a;
      logic [XW-1:0]     b;
      logic [XW-1:0]     imm;
      logic              ld;
      logic              st;
      logic              sub;
      logic              wen;
      logic              halt;
   } idex_t;

   typedef struct packed {
      logic              nop;
      logic [XW-1:0]     alu;
      logic [XW-1:0]     sdata;
      logic [REG_AW-1:0] dst;
      logic              ld;
      logic              st;
      logic              wen;
      logic              halt;
   } exmem_t;

   typedef struct packed {
      logic              nop;
      logic [XW-1:0]     wdata;
      logic [REG_AW-1:0] dst;
      logic              wen;
      logic              halt;
   } memwb_t;

endpackage

// File: rtl/pipe5_bytemem.sv
module pipe5_bytemem #(
   parameter int BYTES    = 256,
   parameter int RD_PORTS = 1,
   localparam int AW      = $clog2(BYTES)
) (
   input  logic                          clk,
   input  logic                          ld_en,
   input  logic [AW-1:0]                 ld_addr,
   input  logic [7:0]                    ld_byte,
   input  logic                          wr_en,
   input  logic [AW-1:0]                 wr_addr,
   input  logic [31:0]                   wr_word,
   input  logic [RD_PORTS-1:0][AW-1:0]   rd_addr,
   output logic [RD_PORTS-1:0][31:0]     rd_word
);

   if (BYTES < 16 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("pipe5_bytemem: BYTES must be a power of two of at least 16");
   end
   if (RD_PORTS < 1) begin : g_bad_ports
      $error("pipe5_bytemem: RD_PORTS must be at least 1");
   end

   logic [7:0] mem [BYTES];

   always_ff @(posedge clk) begin
      if (ld_en) begin
         mem[ld_addr] <= ld_byte;
      end else if (wr_en) begin
         for (int k = 0; k < 4; k++) begin
            mem[wr_addr + AW'(k)] <= wr_word[31-8*k -: 8];
         end
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      for (genvar k = 0; k < 4; k++) begin : g_byte
         assign rd_word[p][31-8*k -: 8] = mem[rd_addr[p] + AW'(k)];
      end
   end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
   parameter int NREG     = 32,
   parameter int W        = 32,
   parameter int RD_PORTS = 2,
   localparam int AW      = $clog2(NREG)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [AW-1:0]               wa,
   input  logic [W-1:0]                wd,
   input  logic [RD_PORTS-1:0][AW-1:0] ra,
   output logic [RD_PORTS-1:0][W-1:0]  rd,
   input  logic [AW-1:0]               dbg_ra,
   output logic [W-1:0]                dbg_rd
);

   if (NREG != (1 << AW) || NREG < 2) begin : g_bad_nreg
      $error("pipe5_regfile: NREG must be a power of two of at least 2");
   end

   logic [W-1:0] regs [NREG];
   logic         wr_live;

   assign wr_live = we && (wa != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (wr_live) begin
         regs[wa] <= wd;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd[p] = (wr_live && wa == ra[p]) ? wd : regs[ra[p]];
   end

   assign dbg_rd = regs[dbg_ra];

endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
   import pipe5_pkg::*;
(
   input  logic              dec_valid,
   input  logic [REG_AW-1:0] dec_rs,
   input  logic [REG_AW-1:0] dec_rt,
   input  logic              dec_use_rs,
   input  logic              dec_use_rt,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic [REG_AW-1:0] ex_rs,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic              mem_wr,
   input  logic              mem_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              wb_wr,
   input  logic [REG_AW-1:0] wb_dst,
   output logic              stall,
   output fwd_e              fwd_a,
   output fwd_e              fwd_b
);

   function automatic fwd_e pick(input logic [REG_AW-1:0] src);
      if (src != '0 && mem_wr && !mem_load && mem_dst == src) return FWD_EXM;
      if (src != '0 && wb_wr && wb_dst == src)                return FWD_MWB;
      return FWD_RF;
   endfunction

   assign stall = dec_valid && ex_load && (ex_dst != '0) &&
                  ((dec_use_rs && dec_rs == ex_dst) || (dec_use_rt && dec_rt == ex_dst));

   assign fwd_a = pick(ex_rs);
   assign fwd_b = pick(ex_rt);

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int  MEM_BYTES = 256,
   localparam int MAW       = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_sel,
   input  logic [MAW-1:0]    ld_addr,
   input  logic [7:0]        ld_byte,
   output logic              halted,
   output logic [XW-1:0]     dbg_pc,
   output logic [3:0]        dbg_stage_nop,
   output logic              dbg_wb_en,
   output logic [REG_AW-1:0] dbg_wb_reg,
   output logic [XW-1:0]     dbg_wb_data,
   input  logic [REG_AW-1:0] dbg_reg_sel,
   output logic [XW-1:0]     dbg_reg_val,
   input  logic [MAW-1:0]    dbg_mem_addr,
   output logic [XW-1:0]     dbg_mem_word
);

   if (MEM_BYTES < 16 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_mem
      $error("pipe5_core: MEM_BYTES must be a power of two of at least 16");
   end

   logic [XW-1:0] pc;
   logic          fetch_stop, halted_q;
   ifid_t         ifid;
   idex_t         idex, idex_d;
   exmem_t        exmem, exmem_d;
   memwb_t        memwb, memwb_d;
   logic [XW-1:0] fetch_word, dmem_rd;
   logic [1:0][MAW-1:0] dmem_ra;
   logic [1:0][XW-1:0]  dmem_rw;

   // ---------------- memories ----------------
   pipe5_bytemem #(.BYTES(MEM_BYTES), .RD_PORTS(1)) u_imem (
      .clk(clk), .ld_en(ld_en && !ld_sel), .ld_addr(ld_addr), .ld_byte(ld_byte),
      .wr_en(1'b0), .wr_addr('0), .wr_word('0),
      .rd_addr(pc[MAW-1:0]), .rd_word(fetch_word));

   assign dmem_ra      = {dbg_mem_addr, exmem.alu[MAW-1:0]};
   assign dmem_rd      = dmem_rw[0];
   assign dbg_mem_word = dmem_rw[1];

   pipe5_bytemem #(.BYTES(MEM_BYTES), .RD_PORTS(2)) u_dmem (
      .clk(clk), .ld_en(ld_en && ld_sel), .ld_addr(ld_addr), .ld_byte(ld_byte),
      .wr_en(!exmem.nop && exmem.st), .wr_addr(exmem.alu[MAW-1:0]),
      .wr_word(exmem.sdata), .rd_addr(dmem_ra), .rd_word(dmem_rw));

   // ---------------- decode ----------------
   logic [5:0]        op, fn;
   logic [REG_AW-1:0] rs, rt, rd;
   logic [XW-1:0]     imm_sx, rs_val, rt_val, br_target;
   logic              dec_valid, is_halt, is_alu, is_lw, is_sw, is_beq;
   logic              use_rs, use_rt, br_taken, stall, halt_fetch;
   logic [1:0][REG_AW-1:0] rf_ra;
   logic [1:0][XW-1:0]     rf_rd;
   fwd_e              fwd_a, fwd_b;

   assign op        = ifid.instr[31:26];
   assign rs        = ifid.instr[25:21];
   assign rt        = ifid.instr[20:16];
   assign rd        = ifid.instr[15:11];
   assign fn        = ifid.instr[5:0];
   assign imm_sx    = {{(XW-16){ifid.instr[15]}}, ifid.instr[15:0]};
   assign dec_valid = !ifid.nop;
   assign is_halt   = ifid.instr == HALT_WORD;
   assign is_alu    = op == OP_ALU && (fn == FN_ADD || fn == FN_SUB);
   assign is_lw     = op == OP_LW;
   assign is_sw     = op == OP_SW;
   assign is_beq    = op == OP_BEQ;
   assign use_rs    = is_alu || is_lw || is_sw;
   assign use_rt    = is_alu || is_sw;

   assign rf_ra  = {rt, rs};
   assign rs_val = rf_rd[0];
   assign rt_val = rf_rd[1];

   pipe5_regfile #(.NREG(1 << REG_AW), .W(XW), .RD_PORTS(2)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(!memwb.nop && memwb.wen), .wa(memwb.dst), .wd(memwb.wdata),
      .ra(rf_ra), .rd(rf_rd), .dbg_ra(dbg_reg_sel), .dbg_rd(dbg_reg_val));

   assign br_taken  = dec_valid && is_beq && (rs_val == rt_val);
   assign br_target = ifid.pc4 + (imm_sx << 2);

   pipe5_hazard u_haz (
      .dec_valid(dec_valid), .dec_rs(rs), .dec_rt(rt),
      .dec_use_rs(use_rs), .dec_use_rt(use_rt),
      .ex_load(!idex.nop && idex.ld && idex.wen), .ex_dst(idex.dst),
      .ex_rs(idex.rs), .ex_rt(idex.rt),
      .mem_wr(!exmem.nop && exmem.wen), .mem_load(exmem.ld), .mem_dst(exmem.dst),
      .wb_wr(!memwb.nop && memwb.wen), .wb_dst(memwb.dst),
      .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b));

   assign halt_fetch = !fetch_stop && !stall && !br_taken && (fetch_word == HALT_WORD);

   // ---------------- fetch and fetch/decode register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc         <= '0;
         fetch_stop <= 1'b0;
         ifid       <= '{nop: 1'b1, default: '0};
      end else if (stall) begin
         pc   <= pc;
         ifid <= ifid;
      end else if (br_taken) begin
         pc       <= br_target;
         ifid.nop <= 1'b1;
      end else if (fetch_stop) begin
         ifid.nop <= 1'b1;
      end else begin
         ifid       <= '{nop: 1'b0, instr: fetch_word, pc4: pc + XW'(4)};
         pc         <= halt_fetch ? pc : pc + XW'(4);
         fetch_stop <= halt_fetch;
      end
   end

   // ---------------- decode/execute register ----------------
   always_comb begin
      idex_d     = '0;
      idex_d.nop = 1'b1;
      if (dec_valid && !stall) begin
         idex_d.nop  = 1'b0;
         idex_d.rs   = rs;
         idex_d.rt   = rt;
         idex_d.dst  = is_alu ? rd : rt;
         idex_d.a    = rs_val;
         idex_d.b    = rt_val;
         idex_d.imm  = imm_sx;
         idex_d.ld   = is_lw;
         idex_d.st   = is_sw;
         idex_d.sub  = fn == FN_SUB;
         idex_d.wen  = (is_alu && rd != '0) || (is_lw && rt != '0);
         idex_d.halt = is_halt;
      end
   end

   // ---------------- execute ----------------
   logic [XW-1:0] op_a, op_b;

   always_comb begin
      unique case (fwd_a)
         FWD_EXM: op_a = exmem.alu;
         FWD_MWB: op_a = memwb.wdata;
         default: op_a = idex.a;
      endcase
      unique case (fwd_b)
         FWD_EXM: op_b = exmem.alu;
         FWD_MWB: op_b = memwb.wdata;
         default: op_b = idex.b;
      endcase
   end

   always_comb begin
      exmem_d       = '0;
      exmem_d.nop   = idex.nop;
      exmem_d.alu   = (idex.ld || idex.st) ? op_a + idex.imm :
                      idex.sub             ? op_a - op_b     : op_a + op_b;
      exmem_d.sdata = op_b;
      exmem_d.dst   = idex.dst;
      exmem_d.ld    = idex.ld;
      exmem_d.st    = idex.st;
      exmem_d.wen   = idex.wen;
      exmem_d.halt  = idex.halt;
   end

   // ---------------- memory ----------------
   always_comb begin
      memwb_d.nop   = exmem.nop;
      memwb_d.wdata = exmem.ld ? dmem_rd : exmem.alu;
      memwb_d.dst   = exmem.dst;
      memwb_d.wen   = exmem.wen;
      memwb_d.halt  = exmem.halt;
   end

   // ---------------- back-end registers and writeback ----------------
   logic wb_halt;
   assign wb_halt = !memwb.nop && memwb.halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idex     <= '{nop: 1'b1, default: '0};
         exmem    <= '{nop: 1'b1, default: '0};
         memwb    <= '{nop: 1'b1, default: '0};
         halted_q <= 1'b0;
      end else begin
         idex     <= idex_d;
         exmem    <= exmem_d;
         memwb    <= memwb_d;
         halted_q <= halted_q || wb_halt;
      end
   end

   assign halted        = halted_q;
   assign dbg_pc        = pc;
   assign dbg_stage_nop = {memwb.nop, exmem.nop, idex.nop, ifid.nop};
   assign dbg_wb_en     = !memwb.nop && memwb.wen;
   assign dbg_wb_reg    = memwb.dst;
   assign dbg_wb_data   = memwb.wdata;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        halted,
   input logic [3:0]  stage_nop,
   input logic        stall,
   input logic        br_taken,
   input logic        fetch_stop,
   input logic        wb_halt,
   input logic [31:0] pc,
   input logic [4:0]  reg_sel,
   input logic [31:0] reg_val
);

   // R6
   halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R6
   halted_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> $past(wb_halt));

   // R6
   stop_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stop |=> $stable(pc));

   // R4
   stall_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(pc));

   // R4
   stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> stage_nop[1]);

   // R5
   branch_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> stage_nop[0]);

   // R10
   idle_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> stage_nop == 4'hF);

   // R7
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 5'd0) |-> (reg_val == 32'd0));

endmodule

bind pipe5_core pipe5_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .halted(halted), .stage_nop(dbg_stage_nop),
   .stall(stall), .br_taken(br_taken), .fetch_stop(fetch_stop),
   .wb_halt(wb_halt), .pc(pc), .reg_sel(dbg_reg_sel), .reg_val(dbg_reg_val));

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb;

   localparam int MB = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0, ld_sel = 1'b0;
   logic [7:0]  ld_addr = '0, ld_byte = '0;
   logic        halted;
   logic [31:0] dbg_pc, dbg_wb_data, dbg_reg_val, dbg_mem_word;
   logic [3:0]  dbg_stage_nop;
   logic        dbg_wb_en;
   logic [4:0]  dbg_wb_reg, dbg_reg_sel = '0;
   logic [7:0]  dbg_mem_addr = '0;

   always #2 clk = ~clk;

   pipe5_core #(.MEM_BYTES(MB)) u_dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
      .ld_byte(ld_byte), .halted(halted), .dbg_pc(dbg_pc), .dbg_stage_nop(dbg_stage_nop),
      .dbg_wb_en(dbg_wb_en), .dbg_wb_reg(dbg_wb_reg), .dbg_wb_data(dbg_wb_data),
      .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
      .dbg_mem_addr(dbg_mem_addr), .dbg_mem_word(dbg_mem_word));

   int    n_chk = 0, n_err = 0;
   string cur_tag = "";
   logic  mon_on = 1'b0;
   logic [36:0] exp_q[$];

   logic [7:0]  iimg [MB];
   logic [7:0]  dimg [MB];
   logic [7:0]  mdat [MB];
   logic [31:0] mreg [32];
   int          exp_cycles;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(logic [4:0] s, logic [4:0] t, logic [4:0] d, logic [5:0] f);
      return {6'h00, s, t, d, 5'h00, f};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] o, logic [4:0] s, logic [4:0] t, logic [15:0] im);
      return {o, s, t, im};
   endfunction

   task automatic put_w(input bit to_d, input int addr, input logic [31:0] w);
      for (int k = 0; k < 4; k++) begin
         if (to_d) dimg[(addr + k) % MB] = w[31-8*k -: 8];
         else      iimg[(addr + k) % MB] = w[31-8*k -: 8];
      end
   endtask

   function automatic logic [31:0] get_w(input bit from_d, input int addr);
      logic [31:0] w;
      for (int k = 0; k < 4; k++)
         w[31-8*k -: 8] = from_d ? mdat[(addr + k) % MB] : iimg[(addr + k) % MB];
      return w;
   endfunction

   // driver / reference: architectural execution, pushes expected writebacks
   task automatic run_model();
      int pc = 0, nexec = 0, nstall = 0, ntaken = 0;
      int last_ld = -1;
      for (int i = 0; i < MB; i++) mdat[i] = dimg[i];
      for (int i = 0; i < 32; i++) mreg[i] = 0;
      for (int step = 0; step < 2000; step++) begin
         logic [31:0] w, a, v;
         logic [5:0]  o, f;
         logic [4:0]  s, t, d;
         logic [31:0] sx;
         w = get_w(1'b0, pc);
         if (w == 32'hFFFF_FFFF) break;
         o = w[31:26]; s = w[25:21]; t = w[20:16]; d = w[15:11]; f = w[5:0];
         sx = {{16{w[15]}}, w[15:0]};
         if (last_ld > 0 && (((o == 6'h00 || o == 6'h23 || o == 6'h2B) && s == 5'(last_ld)) ||
                             ((o == 6'h00 || o == 6'h2B) && t == 5'(last_ld))))
            nstall++;
         last_ld = -1;
         nexec++;
         if (o == 6'h00) begin
            v = (f == 6'h22) ? mreg[s] - mreg[t] : mreg[s] + mreg[t];
            if (d != 0) begin mreg[d] = v; exp_q.push_back({d, v}); end
            pc += 4;
         end else if (o == 6'h23) begin
            a = mreg[s] + sx;
            v = get_w(1'b1, int'(a[7:0]));
            if (t != 0) begin mreg[t] = v; exp_q.push_back({t, v}); last_ld = int'(t); end
            pc += 4;
         end else if (o == 6'h2B) begin
            a = mreg[s] + sx;
            for (int k = 0; k < 4; k++) mdat[(int'(a[7:0]) + k) % MB] = mreg[t][31-8*k -: 8];
            pc += 4;
         end else begin
            if (mreg[s] == mreg[t]) begin ntaken++; pc = pc + 4 + int'(sx) * 4; end
            else pc += 4;
         end
         pc = pc % MB;
      end
      exp_cycles = nexec + nstall + ntaken + 5;
   endtask

   // monitor: compares each writeback with the head of the queue
   always @(negedge clk) begin
      if (mon_on && dbg_wb_en) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL %s extra writeback actual=r%0d:%h expected=none", cur_tag, dbg_wb_reg, dbg_wb_data);
         end else begin
            logic [36:0] e;
            e = exp_q.pop_front();
            chk({cur_tag, " writeback reg"}, 32'(dbg_wb_reg), 32'(e[36:32]));
            chk({cur_tag, " writeback data"}, dbg_wb_data, e[31:0]);
         end
      end
   end

   task automatic run_prog(input string tag);
      int cyc = 0;
      cur_tag = tag;
      mon_on = 1'b0;
      exp_q.delete();
      @(negedge clk); rst_n = 1'b0;
      for (int i = 0; i < 2 * MB; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_sel = (i >= MB); ld_addr = 8'(i % MB);
         ld_byte = (i >= MB) ? dimg[i % MB] : iimg[i % MB];
      end
      @(negedge clk); ld_en = 1'b0;
      // R9 reset state
      chk({tag, " R9 nop bits"}, 32'(dbg_stage_nop), 32'hF);
      chk({tag, " R9 halted"}, 32'(halted), 32'h0);
      chk({tag, " R9 pc"}, dbg_pc, 32'h0);
      for (int r = 0; r < 32; r++) begin
         dbg_reg_sel = 5'(r); #0.2;
         chk({tag, " R9 register clear"}, dbg_reg_val, 32'h0);
      end
      // R1 byte order through the debug port, aligned and unaligned
      dbg_mem_addr = 8'd0; #0.2;
      chk({tag, " R1 word at 0"}, dbg_mem_word, {dimg[0], dimg[1], dimg[2], dimg[3]});
      dbg_mem_addr = 8'd1; #0.2;
      chk({tag, " R1 word at 1"}, dbg_mem_word, {dimg[1], dimg[2], dimg[3], dimg[4]});
      run_model();
      mon_on = 1'b1;
      @(negedge clk); rst_n = 1'b1;
      while (cyc < 5000) begin
         @(posedge clk); #1;
         cyc++;
         if (halted) break;
      end
      chk({tag, " R4 R5 R6 cycles to halted"}, 32'(cyc), 32'(exp_cycles));
      @(negedge clk);
      mon_on = 1'b0;
      chk({tag, " R6 writebacks outstanding"}, 32'(exp_q.size()), 32'h0);
      // R10 all stages idle once halted
      chk({tag, " R10 nop bits halted"}, 32'(dbg_stage_nop), 32'hF);
      repeat (3) @(negedge clk);
      chk({tag, " R6 halted stays"}, 32'(halted), 32'h1);
      for (int r = 0; r < 32; r++) begin
         dbg_reg_sel = 5'(r); #0.2;
         chk({tag, (r == 0) ? " R7 register" : " R2 register"}, dbg_reg_val, mreg[r]);
      end
      for (int a = 0; a < MB; a += 4) begin
         dbg_mem_addr = 8'(a); #0.2;
         chk({tag, " R1 data word"}, dbg_mem_word, get_w(1'b1, a));
      end
   endtask

   task automatic clear_imgs();
      for (int i = 0; i < MB; i++) begin iimg[i] = 8'h00; dimg[i] = 8'h00; end
   endtask

   initial begin
      #800000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      // Program A: forwarding, load-use stalls, writes to register 0 (R3 R4 R7)
      clear_imgs();
      put_w(1, 0, 32'd5); put_w(1, 4, 32'd7); put_w(1, 8, 32'hA1B2C3D4);
      put_w(0, 0,  enc_i(6'h23, 0, 1, 16'd0));
      put_w(0, 4,  enc_i(6'h23, 0, 2, 16'd4));
      put_w(0, 8,  enc_r(1, 2, 3, 6'h20));       // R4 stall on r2
      put_w(0, 12, enc_r(3, 1, 4, 6'h22));       // R3 from execute/memory
      put_w(0, 16, enc_r(4, 3, 5, 6'h20));       // R3 both distances
      put_w(0, 20, enc_i(6'h2B, 0, 5, 16'd12));
      put_w(0, 24, enc_i(6'h23, 0, 6, 16'd12));
      put_w(0, 28, enc_i(6'h2B, 0, 6, 16'd16));  // R4 stall for store data
      put_w(0, 32, enc_r(1, 1, 0, 6'h20));       // R7 write to r0 dropped
      put_w(0, 36, enc_r(0, 6, 7, 6'h20));
      put_w(0, 40, enc_i(6'h23, 0, 8, 16'd9));   // R1 unaligned big-endian load
      put_w(0, 44, 32'hFFFF_FFFF);
      run_prog("progA R3 R4");

      // Program B: taken/not-taken branches, same-cycle writeback read (R5 R8 R6)
      clear_imgs();
      put_w(1, 0, 32'd3); put_w(1, 4, 32'd3);
      put_w(0, 0,  enc_i(6'h23, 0, 1, 16'd0));
      put_w(0, 4,  enc_i(6'h23, 0, 2, 16'd4));
      put_w(0, 8,  enc_r(0, 0, 3, 6'h20));
      put_w(0, 12, enc_r(0, 0, 9, 6'h20));
      put_w(0, 16, enc_i(6'h04, 1, 2, 16'd2));   // R8 r2 written back this cycle; taken
      put_w(0, 20, enc_r(1, 1, 4, 6'h20));       // R5 killed
      put_w(0, 24, enc_r(1, 1, 5, 6'h20));       // skipped
      put_w(0, 28, enc_i(6'h04, 1, 3, 16'd5));   // not taken
      put_w(0, 32, enc_r(1, 2, 6, 6'h20));
      put_w(0, 36, enc_i(6'h04, 0, 0, 16'd1));   // taken
      put_w(0, 40, enc_r(6, 6, 7, 6'h20));       // R5 killed
      put_w(0, 44, enc_i(6'h2B, 0, 6, 16'd8));
      put_w(0, 48, 32'hFFFF_FFFF);
      put_w(0, 52, enc_r(1, 1, 8, 6'h20));       // R6 never executes
      run_prog("progB R5 R8");
      dbg_reg_sel = 5'd8; #0.2;
      chk("progB R6 past halt", dbg_reg_val, 32'h0);
      dbg_reg_sel = 5'd4; #0.2;
      chk("progB R5 squashed", dbg_reg_val, 32'h0);

      // Program C: counted loop with a backward branch (R5 R8)
      clear_imgs();
      put_w(1, 0, 32'd3); put_w(1, 4, 32'd1);
      put_w(0, 0,  enc_i(6'h23, 0, 1, 16'd0));
      put_w(0, 4,  enc_i(6'h23, 0, 2, 16'd4));
      put_w(0, 8,  enc_r(0, 0, 3, 6'h20));
      put_w(0, 12, enc_r(0, 0, 4, 6'h20));
      put_w(0, 16, enc_r(3, 1, 3, 6'h20));
      put_w(0, 20, enc_r(1, 2, 1, 6'h22));
      put_w(0, 24, enc_r(0, 0, 9, 6'h20));
      put_w(0, 28, enc_r(0, 0, 9, 6'h20));
      put_w(0, 32, enc_i(6'h04, 1, 0, 16'd1));   // R8 r1 in writeback
      put_w(0, 36, enc_i(6'h04, 0, 0, 16'hFFFA)); // back to 16
      put_w(0, 40, enc_i(6'h2B, 0, 3, 16'd8));
      put_w(0, 44, 32'hFFFF_FFFF);
      run_prog("progC R5 R8");
      dbg_mem_addr = 8'd8; #0.2;
      chk("progC R5 loop sum", dbg_mem_word, 32'd6);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule